// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit linear address into a 32-bit physical address. It does so by reading two entries from a translation structure held in memory. The upper ten address bits select a word in a page directory. The directory base frame is supplied on an input and captured when a request is accepted. That directory word names the frame of a second-level table. The next ten bits select a word in that table, and the table word supplies the 20-bit frame of the target page. The low twelve bits pass straight through as the offset within the page.

Each request carries the linear address, a write flag and a 2-bit privilege level. Level 3 is user and levels 0 to 2 are supervisor. The block checks that both entries are marked valid. It then checks user access and write permission, and a right counts only when both the directory word and the table word grant it. On success it records use in memory. The used flag is set in both entries. The modified flag is set only in the table entry, and only for a write. An entry is written back only when one of its bits actually changes.

The walker reports one result per request: either a physical address, or a fault with a 2-bit code that gives the cause and the level. Memory is reached through a single request/acknowledge port that carries 32-bit reads and writes.

Top module: `pt_walker`

## Requirements
- R1: After a request is accepted, the first memory access is a read at `{dir_base_frame, laddr[31:22], 2'b00}`.
- R2: If the directory word has bit 0 (valid) set, the second access is a read at `{dirword[31:12], laddr[21:12], 2'b00}`.
- R3: On success `rsp_fault` is 0 and `rsp_paddr` equals `{tblword[31:12], laddr[11:0]}`; on a fault `rsp_paddr` is 0.
- R4: A directory word with bit 0 clear ends the walk with code 2'b00, no second read and no write. A table word with bit 0 clear ends it with code 2'b10. In both cases the other bits of that word have no effect.
- R5: Bit 1 of an entry (0 = read-only) denies writes only at privilege 3. Privileges 0, 1 and 2 are never denied for any bit pattern.
- R6: Bit 2 of an entry (0 = supervisor only) denies any access at privilege 3. A denial found in the directory word gives code 2'b01; otherwise a denial found in the table word gives code 2'b11. Code bit 1 is the level (1 = table) and code bit 0 is the cause (1 = protection).
- R7: On success, bit 5 (used) is set in both entries. Each entry is written back as its read value OR'd with the new flags, and only if that value differs from what was read.
- R8: On a successful write access, bit 6 (modified) is set in the table entry. Bit 6 of the directory word is never changed.
- R9: Write-backs go directory first, then table, then the response. A walk that faults writes nothing.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values and `mem_req` stays high.
- R11: During reset, `req_ready` is 1 and both `mem_req` and `rsp_valid` are 0.
- R12: `rsp_valid` is a one-cycle pulse, one per accepted request. `req_ready` is 0 from acceptance until that pulse has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_cpl | input | 2 | Privilege level, 3 = user |
| dir_base_frame | input | 20 | Frame number of the page directory |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rsp_valid | output | 1 | Result present for one cycle |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 2 | Fault code: bit 1 level, bit 0 cause |
| rsp_paddr | output | 32 | Physical address on success |

## Verification
The checker watches several properties on every cycle:
- the memory port holds its address, direction and data while an access waits for acknowledge;
- the first access of each walk is a directory read at the expected address;
- every write-back carries an entry with the valid and used bits set;
- a walk that reports a fault has written nothing;
- the response is a single pulse that never overlaps an idle walker.

Some behaviour depends on entry contents and on the exact order of writes, and only the bench's sweep shows it. The bench runs every combination of directory flags, table flags, write flag and privilege class. It checks the fault code chosen, the table-read address, the count and values of the write-backs, and that the modified bit stays clear in the directory word.

// File: rtl/pt_walker_pkg.sv
// Package: shared constants and state type for the page table walker.
// Assumes 32-bit entries with flag bits in the low 12 bits.
package pt_walker_pkg;

    localparam int FLAG_VALID    = 0;
    localparam int FLAG_WRITABLE = 1;
    localparam int FLAG_USER     = 2;
    localparam int FLAG_USED     = 5;
    localparam int FLAG_MODIFIED = 6;

    // Fault code: bit 1 = level (1 table), bit 0 = cause (1 protection)
    localparam logic [1:0] CODE_DIR_ABSENT = 2'b00;
    localparam logic [1:0] CODE_DIR_DENIED = 2'b01;
    localparam logic [1:0] CODE_TBL_ABSENT = 2'b10;
    localparam logic [1:0] CODE_TBL_DENIED = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_TBL_RD,
        ST_EVAL,
        ST_DIR_WB,
        ST_TBL_WB,
        ST_DONE
    } walk_st_t;

endpackage

// File: rtl/pt_addr_gen.sv
// Module: forms the byte address of one entry from a table's base frame and an index.
// Assumes 4-byte entries and that the index field fits inside one frame.
module pt_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [IDX_W-1:0]        index,
    output logic [ADDR_W-1:0]       addr
);
    localparam int PAD_W = ADDR_W - IDX_W - 2;

    // Purpose: base frame shifted to a byte address plus index scaled by entry size.
    assign addr = {base_frame, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, index, 2'b00};
endmodule

// File: rtl/pt_entry_eval.sv
// Module: judges one entry's rights for an access and forms its updated value.
// Assumes the caller checks the valid bit separately. IS_LEAF selects whether
// writes set the modified flag (table level) or not (directory level).
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int ENT_W   = 32,
    parameter bit IS_LEAF = 1'b0
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_user,
    output logic             deny,
    output logic [ENT_W-1:0] upd,
    output logic             changed
);
    logic [ENT_W-1:0] set_mask;

    // Purpose: choose which flags a successful access sets at this level.
    generate
        if (IS_LEAF) begin : g_leaf
            assign set_mask = (ENT_W'(1) << FLAG_USED)
                            | (is_write ? (ENT_W'(1) << FLAG_MODIFIED) : '0);
        end else begin : g_dir
            assign set_mask = ENT_W'(1) << FLAG_USED;
        end
    endgenerate

    // Purpose: user accesses need the user bit; user writes also need the writable bit.
    assign deny    = is_user && (!entry[FLAG_USER] || (is_write && !entry[FLAG_WRITABLE]));
    // Purpose: new value and whether a write-back is needed.
    assign upd     = entry | set_mask;
    assign changed = (upd != entry);
endmodule

// File: rtl/pt_walker.sv
// Module: two-level page table walker. It reads the directory entry, then the
// table entry, evaluates combined rights, writes back changed flags in order
// (directory then table), and reports a physical address or a fault code.
// Assumes a memory that holds a request until it acknowledges it, and that
// 2*IDX_W + OFF_W equals ADDR_W.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_laddr,
    input  logic                    req_write,
    input  logic [1:0]              req_cpl,
    input  logic [ADDR_W-OFF_W-1:0] dir_base_frame,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [ADDR_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [ADDR_W-1:0]       mem_rdata,
    output logic                    rsp_valid,
    output logic                    rsp_fault,
    output logic [1:0]              rsp_code,
    output logic [ADDR_W-1:0]       rsp_paddr
);
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int TIDX_LO = OFF_W;
    localparam int TIDX_HI = OFF_W + IDX_W - 1;
    localparam int DIDX_LO = ADDR_W - IDX_W;

    walk_st_t             st;
    logic [ADDR_W-1:0]    la_q;
    logic                 wr_q;
    logic                 usr_q;
    logic [FRAME_W-1:0]   base_q;
    logic [ADDR_W-1:0]    pde_q;
    logic [ADDR_W-1:0]    pte_q;
    logic                 fault_q;
    logic [1:0]           code_q;

    logic [ADDR_W-1:0]    dir_addr;
    logic [ADDR_W-1:0]    tbl_addr;
    logic                 dir_deny;
    logic                 tbl_deny;
    logic [ADDR_W-1:0]    pde_new;
    logic [ADDR_W-1:0]    pte_new;
    logic                 dir_chg;
    logic                 tbl_chg;

    pt_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_dir_addr (
        .base_frame (base_q),
        .index      (la_q[ADDR_W-1:DIDX_LO]),
        .addr       (dir_addr)
    );

    pt_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_tbl_addr (
        .base_frame (pde_q[ADDR_W-1:OFF_W]),
        .index      (la_q[TIDX_HI:TIDX_LO]),
        .addr       (tbl_addr)
    );

    pt_entry_eval #(.ENT_W(ADDR_W), .IS_LEAF(1'b0)) i_dir_eval (
        .entry    (pde_q),
        .is_write (wr_q),
        .is_user  (usr_q),
        .deny     (dir_deny),
        .upd      (pde_new),
        .changed  (dir_chg)
    );

    pt_entry_eval #(.ENT_W(ADDR_W), .IS_LEAF(1'b1)) i_tbl_eval (
        .entry    (pte_q),
        .is_write (wr_q),
        .is_user  (usr_q),
        .deny     (tbl_deny),
        .upd      (pte_new),
        .changed  (tbl_chg)
    );

    // Purpose: walk sequencing, entry capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            la_q    <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            base_q  <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            fault_q <= 1'b0;
            code_q  <= 2'b00;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        la_q    <= req_laddr;
                        wr_q    <= req_write;
                        usr_q   <= (req_cpl == 2'd3);
                        base_q  <= dir_base_frame;
                        fault_q <= 1'b0;
                        code_q  <= 2'b00;
                        st      <= ST_DIR_RD;
                    end
                end
                ST_DIR_RD: begin
                    if (mem_ack) begin
                        pde_q <= mem_rdata;
                        if (!mem_rdata[FLAG_VALID]) begin
                            fault_q <= 1'b1;
                            code_q  <= CODE_DIR_ABSENT;
                            st      <= ST_DONE;
                        end else begin
                            st <= ST_TBL_RD;
                        end
                    end
                end
                ST_TBL_RD: begin
                    if (mem_ack) begin
                        pte_q <= mem_rdata;
                        st    <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (!pte_q[FLAG_VALID]) begin
                        fault_q <= 1'b1;
                        code_q  <= CODE_TBL_ABSENT;
                        st      <= ST_DONE;
                    end else if (dir_deny) begin
                        fault_q <= 1'b1;
                        code_q  <= CODE_DIR_DENIED;
                        st      <= ST_DONE;
                    end else if (tbl_deny) begin
                        fault_q <= 1'b1;
                        code_q  <= CODE_TBL_DENIED;
                        st      <= ST_DONE;
                    end else if (dir_chg) begin
                        st <= ST_DIR_WB;
                    end else if (tbl_chg) begin
                        st <= ST_TBL_WB;
                    end else begin
                        st <= ST_DONE;
                    end
                end
                ST_DIR_WB: begin
                    if (mem_ack) begin
                        st <= tbl_chg ? ST_TBL_WB : ST_DONE;
                    end
                end
                ST_TBL_WB: begin
                    if (mem_ack) begin
                        st <= ST_DONE;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Purpose: memory port drive, decoded from the walk state.
    always_comb begin
        mem_req   = (st == ST_DIR_RD) || (st == ST_TBL_RD) || (st == ST_DIR_WB) || (st == ST_TBL_WB);
        mem_we    = (st == ST_DIR_WB) || (st == ST_TBL_WB);
        mem_addr  = ((st == ST_DIR_RD) || (st == ST_DIR_WB)) ? dir_addr : tbl_addr;
        mem_wdata = (st == ST_DIR_WB) ? pde_new : pte_new;
    end

    // Purpose: handshake and result outputs.
    assign req_ready = (st == ST_IDLE);
    assign rsp_valid = (st == ST_DONE);
    assign rsp_fault = fault_q;
    assign rsp_code  = code_q;
    assign rsp_paddr = fault_q ? '0 : {pte_q[ADDR_W-1:OFF_W], la_q[OFF_W-1:0]};
endmodule

// File: rtl/pt_walker_chk.sv
// Module: property checker for the page table walker, bound to every instance.
// Keeps its own copy of the accepted request to judge the port behaviour.
module pt_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [ADDR_W-1:0]       req_laddr,
    input logic [ADDR_W-OFF_W-1:0] dir_base_frame,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [ADDR_W-1:0]       mem_wdata,
    input logic                    mem_ack,
    input logic                    rsp_valid,
    input logic                    rsp_fault,
    input logic [ADDR_W-1:0]       rsp_paddr
);
    localparam int DIDX_LO = ADDR_W - IDX_W;

    logic [IDX_W-1:0]        didx_c;
    logic [OFF_W-1:0]        off_c;
    logic [ADDR_W-OFF_W-1:0] base_c;
    logic                    first_c;
    logic                    wrote_c;

    // Purpose: record the accepted request and whether this walk has written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            didx_c  <= '0;
            off_c   <= '0;
            base_c  <= '0;
            first_c <= 1'b0;
            wrote_c <= 1'b0;
        end else if (req_valid && req_ready) begin
            didx_c  <= req_laddr[ADDR_W-1:DIDX_LO];
            off_c   <= req_laddr[OFF_W-1:0];
            base_c  <= dir_base_frame;
            first_c <= 1'b1;
            wrote_c <= 1'b0;
        end else if (mem_req && mem_ack) begin
            first_c <= 1'b0;
            if (mem_we) wrote_c <= 1'b1;
        end
    end

    a_r1_first_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && first_c) |-> (!mem_we && mem_addr == {base_c, didx_c, 2'b00}));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_c));

    a_r7_wb_valid_used: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[0] && mem_wdata[5]));

    a_r9_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !wrote_c);

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_laddr      (req_laddr),
    .dir_base_frame (dir_base_frame),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ack        (mem_ack),
    .rsp_valid      (rsp_valid),
    .rsp_fault      (rsp_fault),
    .rsp_paddr      (rsp_paddr)
);

// File: tb/test_pt_walker.sv
// Bench: sweeps every combination of directory flags, table flags, write flag
// and privilege class against a behavioural memory with varying latency.
module test_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpl = 2'd0;
    logic [19:0] dir_base_frame = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int fails = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_addr [4];
    logic [31:0] wr_addr [4];
    logic [31:0] wr_data [4];
    int n_rd = 0;
    int n_wr = 0;
    int lat = 0;
    int wait_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_cpl(req_cpl), .dir_base_frame(dir_base_frame),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Memory responder: acknowledges after lat idle cycles, logs every access.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        if (n_wr < 4) begin
                            wr_addr[n_wr] = mem_addr;
                            wr_data[n_wr] = mem_wdata;
                        end
                        n_wr++;
                    end else begin
                        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                        if (n_rd < 4) rd_addr[n_rd] = mem_addr;
                        n_rd++;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(req_ready === 1'b1, "R11 req_ready", {31'b0, req_ready}, 32'd1);
        check(mem_req === 1'b0, "R11 mem_req", {31'b0, mem_req}, 32'd0);
        check(rsp_valid === 1'b0, "R11 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int it = 0; it < 2048; it++) begin
            logic pP, pRW, pUS, pA, tP, tRW, tUS, tA, tD, w, usr, ddeny, tdeny;
            logic [19:0] base, tframe, pframe;
            logic [9:0]  di, ti;
            logic [11:0] off;
            logic [31:0] pde, pte, pde_addr, pte_addr, exp_paddr;
            logic [31:0] ewa [2];
            logic [31:0] ewd [2];
            logic [1:0]  exp_code;
            logic        exp_fault;
            int exp_rd, exp_wr, cyc;

            {pA, pUS, pRW, pP} = 4'(it);
            {tD, tA, tUS, tRW, tP} = 5'(it >> 4);
            w   = it[9];
            usr = it[10];
            base   = 20'h00100 ^ 20'(it & 15);
            tframe = 20'h40000 + 20'(it);
            pframe = 20'hA0000 ^ 20'(it * 7);
            di  = 10'(it * 37);
            ti  = 10'(it * 91 + 5);
            off = 12'(it * 13 + 1);
            pde = {tframe, 5'(it * 3), 1'(it >> 2), pA, 2'(it >> 1), pUS, pRW, pP};
            pte = {pframe, 5'(it * 5), tD, tA, 2'(it >> 3), tUS, tRW, tP};
            pde_addr = {base, 12'h0} + {20'h0, di, 2'b00};
            pte_addr = {tframe, 12'h0} + {20'h0, ti, 2'b00};

            // Expected outcome from the requirements
            ddeny = usr && (!pUS || (w && !pRW));
            tdeny = usr && (!tUS || (w && !tRW));
            exp_wr = 0;
            exp_paddr = 32'h0;
            exp_fault = 1'b1;
            exp_rd = 2;
            if (!pP) begin
                exp_code = 2'b00; exp_rd = 1;
            end else if (!tP) begin
                exp_code = 2'b10;
            end else if (ddeny) begin
                exp_code = 2'b01;
            end else if (tdeny) begin
                exp_code = 2'b11;
            end else begin
                exp_fault = 1'b0;
                exp_code = 2'b00;
                exp_paddr = {pframe, off};
                if (!pA) begin
                    ewa[exp_wr] = pde_addr; ewd[exp_wr] = pde | 32'h20; exp_wr++;
                end
                if (!tA || (w && !tD)) begin
                    ewa[exp_wr] = pte_addr; ewd[exp_wr] = pte | 32'h20 | (w ? 32'h40 : 32'h0); exp_wr++;
                end
            end

            mem.delete();
            mem[pde_addr] = pde;
            mem[pte_addr] = pte;
            n_rd = 0;
            n_wr = 0;
            lat = it % 3;
            wait_cnt = 0;

            req_valid = 1'b1;
            req_laddr = {di, ti, off};
            req_write = w;
            req_cpl = usr ? 2'd3 : 2'(it % 3);
            dir_base_frame = base;
            @(negedge clk);
            req_valid = 1'b0;
            check(req_ready === 1'b0, "R12 busy", {31'b0, req_ready}, 32'd0);

            cyc = 0;
            while (rsp_valid !== 1'b1 && cyc < 100) begin
                @(negedge clk);
                cyc++;
            end

            check(rsp_fault === exp_fault && rsp_code === exp_code, "R4 R5 R6 fault/code",
                  {29'b0, rsp_fault, rsp_code}, {29'b0, exp_fault, exp_code});
            check(rsp_paddr === exp_paddr, "R3 paddr", rsp_paddr, exp_paddr);
            check(n_rd == exp_rd, "R4 read count", 32'(n_rd), 32'(exp_rd));
            check(rd_addr[0] === pde_addr, "R1 dir addr", rd_addr[0], pde_addr);
            if (exp_rd == 2)
                check(rd_addr[1] === pte_addr, "R2 tbl addr", rd_addr[1], pte_addr);
            check(n_wr == exp_wr, "R7 R9 write count", 32'(n_wr), 32'(exp_wr));
            for (int k = 0; k < exp_wr && k < n_wr; k++) begin
                check(wr_addr[k] === ewa[k], "R9 write order", wr_addr[k], ewa[k]);
                check(wr_data[k] === ewd[k], "R7 R8 write data", wr_data[k], ewd[k]);
            end
            check(mem[pde_addr][6] === pde[6], "R8 dir modified untouched",
                  {31'b0, mem[pde_addr][6]}, {31'b0, pde[6]});

            @(negedge clk);
            check(rsp_valid === 1'b0 && req_ready === 1'b1, "R12 pulse",
                  {30'b0, rsp_valid, req_ready}, 32'd1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule